// File: doc/BRIEF.md
# Program Counter Fetch Unit

This block keeps the program counter of a single-cycle 32-bit processor and presents it as the instruction memory address. On each rising clock edge it does one of three things. It steps forward by one instruction word, or it loads a redirect target from the decode stage, or it keeps its current value while the word coming back from memory is not yet valid.

The word that memory returns passes straight through to the instruction output with no register in the path. Decode therefore sees the instruction for the current address in the same cycle. The counter restarts at a fixed entry address of 0x1000.

Top module: `pc_fetch_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the counter loads 0x1000 on that edge. This holds whatever `fetch_valid`, `jump_req` and `jump_target` are doing.
- R2: When `fetch_valid` is high and `jump_req` is low at a rising edge, `fetch_addr` becomes its previous value plus 4 after that edge.
- R3: When `fetch_valid` and `jump_req` are both high at a rising edge, `fetch_addr` becomes `jump_target` after that edge. The redirect wins over the sequential step.
- R4: When `fetch_valid` is low at a rising edge, `fetch_addr` keeps its value, whether or not `jump_req` is high.
- R5: `fetch_addr` is the registered counter. It changes only at a rising clock edge and never in response to input changes between edges.
- R6: `instr_out` equals `mem_rdata` at all times, combinationally.
- R7: The sequential step wraps modulo 2^32, so 0xFFFFFFFC steps to 0x00000000.
- R8: A redirect whose target equals the current counter leaves `fetch_addr` unchanged, so at the ports it looks the same as a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| jump_req | input | 1 | Redirect request from decode |
| jump_target | input | 32 | Redirect destination address |
| fetch_valid | input | 1 | Memory word for the current address is valid |
| mem_rdata | input | 32 | Instruction memory read data |
| fetch_addr | output | 32 | Current program counter, drives the memory address |
| instr_out | output | 32 | Current instruction, equal to `mem_rdata` |

## Verification
All of the counter state is visible on `fetch_addr`. A wrong next-value choice therefore shows up there one edge after the offending input pattern.

A stall that advances anyway, a step of the wrong size or a redirect that is dropped all change the address seen in the next cycle. A missed reset shows in the first cycle after `rst` falls. The bench compares `fetch_addr` after every edge against values worked out by hand, including the wrap point and the case of a redirect onto the same address.

// File: rtl/pcf_pkg.sv
package pcf_pkg;

    parameter int ADDR_W  = 32;
    parameter int INSTR_W = 32;

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [INSTR_W-1:0] instr_t;

    typedef enum logic [1:0] {
        PC_HOLD     = 2'd0,
        PC_STEP     = 2'd1,
        PC_REDIRECT = 2'd2
    } pc_sel_e;

    typedef struct packed {
        logic  valid;
        logic  jump;
        addr_t target;
    } fetch_ctl_t;

    // Stall dominates; among valid cycles the redirect dominates the step.
    function automatic pc_sel_e pick_sel(input fetch_ctl_t c);
        if (!c.valid)
            return PC_HOLD;
        else if (c.jump)
            return PC_REDIRECT;
        else
            return PC_STEP;
    endfunction

endpackage

// File: rtl/pcf_sel.sv
module pcf_sel
    import pcf_pkg::*;
(
    input  fetch_ctl_t ctl,
    output pc_sel_e    sel
);
    always_comb begin
        sel = pick_sel(ctl);
    end
endmodule

// File: rtl/pcf_next_calc.sv
module pcf_next_calc
    import pcf_pkg::*;
#(
    parameter int STEP_BYTES = 4
) (
    input  pc_sel_e sel,
    input  addr_t   cur_pc,
    input  addr_t   target,
    output addr_t   nxt_pc
);
    localparam addr_t STEP = addr_t'(STEP_BYTES);

    addr_t seq_pc;

    // The step is computed modulo 2^ADDR_W (the carry out is dropped).
    generate
        if ((STEP_BYTES & (STEP_BYTES - 1)) == 0 && STEP_BYTES > 1) begin : g_pow2
            localparam int LSB = $clog2(STEP_BYTES);
            // Low bits are word-aligned by construction; add at word granularity.
            always_comb begin
                seq_pc = {cur_pc[ADDR_W-1:LSB] + 1'b1, cur_pc[LSB-1:0]};
            end
        end else begin : g_generic
            always_comb begin
                seq_pc = cur_pc + STEP;
            end
        end
    endgenerate

    always_comb begin
        unique case (sel)
            PC_STEP:     nxt_pc = seq_pc;
            PC_REDIRECT: nxt_pc = target;
            default:     nxt_pc = cur_pc;
        endcase
    end
endmodule

// File: rtl/pcf_pc_reg.sv
module pcf_pc_reg
    import pcf_pkg::*;
#(
    parameter addr_t ENTRY_ADDR = 32'h0000_1000
) (
    input  logic  clk,
    input  logic  rst,
    input  addr_t nxt_pc,
    output addr_t pc_q
);
    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= ENTRY_ADDR;
        else
            pc_q <= nxt_pc;
    end
endmodule

// File: rtl/pc_fetch_unit.sv
module pc_fetch_unit
    import pcf_pkg::*;
#(
    parameter addr_t ENTRY_ADDR = 32'h0000_1000,
    parameter int    STEP_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               jump_req,
    input  logic [ADDR_W-1:0]  jump_target,
    input  logic               fetch_valid,
    input  logic [INSTR_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0]  fetch_addr,
    output logic [INSTR_W-1:0] instr_out
);
    fetch_ctl_t ctl;
    pc_sel_e    sel;
    addr_t      pc_q;
    addr_t      nxt_pc;

    always_comb begin
        ctl.valid  = fetch_valid;
        ctl.jump   = jump_req;
        ctl.target = jump_target;
    end

    pcf_sel u_sel (
        .ctl (ctl),
        .sel (sel)
    );

    pcf_next_calc #(.STEP_BYTES(STEP_BYTES)) u_next (
        .sel    (sel),
        .cur_pc (pc_q),
        .target (ctl.target),
        .nxt_pc (nxt_pc)
    );

    pcf_pc_reg #(.ENTRY_ADDR(ENTRY_ADDR)) u_pc (
        .clk    (clk),
        .rst    (rst),
        .nxt_pc (nxt_pc),
        .pc_q   (pc_q)
    );

    assign fetch_addr = pc_q;
    assign instr_out  = mem_rdata;
endmodule

// File: rtl/pcf_checker.sv
module pcf_checker
    import pcf_pkg::*;
#(
    parameter addr_t ENTRY_ADDR = 32'h0000_1000,
    parameter int    STEP_BYTES = 4
) (
    input logic  clk,
    input logic  rst,
    input logic  jump_req,
    input addr_t jump_target,
    input logic  fetch_valid,
    input addr_t fetch_addr
);
    localparam addr_t STEP = addr_t'(STEP_BYTES);

    assert_reset_entry_R1: assert property (@(posedge clk)
        rst |=> fetch_addr == ENTRY_ADDR);

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && !jump_req) |=> fetch_addr == $past(fetch_addr) + STEP);

    assert_redirect_R3: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && jump_req) |=> fetch_addr == $past(jump_target));

    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !fetch_valid |=> $stable(fetch_addr));

    assert_self_jump_R8: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && jump_req && jump_target == fetch_addr) |=> $stable(fetch_addr));
endmodule

bind pc_fetch_unit pcf_checker #(
    .ENTRY_ADDR (ENTRY_ADDR),
    .STEP_BYTES (STEP_BYTES)
) u_pcf_checker (
    .clk         (clk),
    .rst         (rst),
    .jump_req    (jump_req),
    .jump_target (jump_target),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr)
);

// File: tb/test_pc_fetch_unit.sv
module test_pc_fetch_unit;
    import pcf_pkg::*;

    localparam int NVEC = 10;

    typedef struct packed {
        logic        valid;
        logic        jump;
        logic [31:0] target;
        logic [31:0] rdata;
        logic [31:0] exp_addr;
        logic [3:0]  req;
    } vec_t;

    // Starting from 0x1000 just after reset.
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 32'h0000_0000, 32'h1111_0000, 32'h0000_1004, 4'd2}, // R2
        '{1'b1, 1'b0, 32'h0000_3000, 32'h1111_0001, 32'h0000_1008, 4'd2}, // R2
        '{1'b0, 1'b1, 32'h0000_2000, 32'h1111_0002, 32'h0000_1008, 4'd4}, // R4 jump ignored
        '{1'b1, 1'b1, 32'h0000_2000, 32'h1111_0003, 32'h0000_2000, 4'd3}, // R3
        '{1'b1, 1'b0, 32'h0000_0000, 32'h1111_0004, 32'h0000_2004, 4'd2}, // R2
        '{1'b1, 1'b1, 32'h0000_2004, 32'h1111_0005, 32'h0000_2004, 4'd8}, // R8
        '{1'b0, 1'b0, 32'h0000_0000, 32'h1111_0006, 32'h0000_2004, 4'd4}, // R4
        '{1'b1, 1'b1, 32'hFFFF_FFFC, 32'h1111_0007, 32'hFFFF_FFFC, 4'd3}, // R3
        '{1'b1, 1'b0, 32'h0000_0000, 32'h1111_0008, 32'h0000_0000, 4'd7}, // R7 wrap
        '{1'b1, 1'b1, 32'h0000_1000, 32'h1111_0009, 32'h0000_1000, 4'd3}  // R3
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        jump_req;
    logic [31:0] jump_target;
    logic        fetch_valid;
    logic [31:0] mem_rdata;
    logic [31:0] fetch_addr;
    logic [31:0] instr_out;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 8 ns period, 125 MHz

    pc_fetch_unit i_pc_fetch_unit (
        .clk         (clk),
        .rst         (rst),
        .jump_req    (jump_req),
        .jump_target (jump_target),
        .fetch_valid (fetch_valid),
        .mem_rdata   (mem_rdata),
        .fetch_addr  (fetch_addr),
        .instr_out   (instr_out)
    );

    task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1; jump_req = 1'b1; jump_target = 32'hDEAD_BEE0;
        fetch_valid = 1'b1; mem_rdata = 32'h0;
        repeat (2) @(negedge clk);
        // R1: reset wins over an active redirect
        chk(1, fetch_addr, 32'h0000_1000);

        rst = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            fetch_valid = VECS[i].valid;
            jump_req    = VECS[i].jump;
            jump_target = VECS[i].target;
            mem_rdata   = VECS[i].rdata;
            #1;
            chk(6, instr_out, VECS[i].rdata);          // R6 pass-through
            @(negedge clk);
            chk(int'(VECS[i].req), fetch_addr, VECS[i].exp_addr);
        end

        // R5: address does not follow inputs between edges
        fetch_valid = 1'b1; jump_req = 1'b1; jump_target = 32'h0000_4000;
        #2;
        chk(5, fetch_addr, 32'h0000_1000);
        jump_target = 32'h0000_5000;
        #1;
        chk(5, fetch_addr, 32'h0000_1000);
        @(negedge clk);
        chk(3, fetch_addr, 32'h0000_5000);

        // R6: instruction output follows read data without a clock edge
        mem_rdata = 32'hCAFE_F00D; #1;
        chk(6, instr_out, 32'hCAFE_F00D);
        mem_rdata = 32'h0000_0013; #1;
        chk(6, instr_out, 32'h0000_0013);

        // R1: synchronous reset from a non-entry address while a stall is requested
        @(negedge clk);
        rst = 1'b1; fetch_valid = 1'b0; jump_req = 1'b0;
        #2;
        chk(1, fetch_addr, 32'h0000_5000);   // synchronous: no change before the edge
        @(negedge clk);
        chk(1, fetch_addr, 32'h0000_1000);
        rst = 1'b0; fetch_valid = 1'b1;
        @(negedge clk);
        chk(2, fetch_addr, 32'h0000_1004);

        finish_run();
    end
endmodule